// File: doc/BRIEF.md
# Ethernet Pause Frame Receive Detector

This block watches the byte stream of every received Ethernet frame and decides whether the frame is a MAC control pause request aimed at this station. It compares three things as the bytes go past: the destination address, the type field and the control opcode. When a frame passes all three checks and closes with a good CRC, the block reports it. It classifies the request from its 16-bit pause time. A non-zero time asks the link partner to stop transmitting (XOFF). A zero time lets it resume (XON).

The block also runs the pause itself. An accepted XOFF loads a countdown held in slot times, where one slot is 64 byte clocks. The transmit side must hold off for as long as that countdown is non-zero. An accepted XON clears the countdown at once. Software can switch off the reaction to received pause frames without touching anything on the transmit side. This gives asymmetric flow control.

Top module: `pause_rx_detect`

## Requirements
- R1: The destination check passes when frame bytes 0..5 equal `cfg_ctrl_mac` or `cfg_station_mac`. Byte 0 is compared with address bits 47:40 and byte 5 with bits 7:0.
- R2: Bytes 12 and 13 must equal `cfg_type`, high byte first (nominally 0x8808).
- R3: Bytes 14 and 15 must equal the opcode 0x0001, high byte first. Any other opcode is rejected.
- R4: A decision is taken only on the byte marked `rx_eof`, and only when `rx_crc_ok` is high on that byte. `pause_seen` is high for exactly the one cycle after that byte's clock edge. A frame with a bad CRC gives no pulse.
- R5: The pause time is taken from bytes 16 and 17, high byte first. `pause_is_xoff` is 1 for a non-zero time and 0 for a zero time. It is updated together with `pause_seen` and holds its value until the next accepted frame.
- R6: An accepted XOFF with time N drives `pause_hold` high for exactly N*64 cycles. The first of those cycles is the cycle in which `pause_seen` is high.
- R7: An accepted XON drops `pause_hold` low in the same cycle in which `pause_seen` is high, ending any pause in progress.
- R8: An XOFF accepted while a pause is running replaces the remaining time. The hold then lasts exactly N*64 cycles from the new pulse.
- R9: While `cfg_rx_pause_en` is low, pause frames have no effect. No pulse is produced and `pause_hold` keeps its current level.
- R10: A frame that ends before byte 17 (fewer than 18 bytes) is never accepted.
- R11: After reset, `pause_seen`, `pause_is_xoff` and `pause_hold` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_sof | input | 1 | Marks the first byte of a frame (with rx_valid) |
| rx_valid | input | 1 | rx_data holds a frame byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | Marks the last byte of a frame (with rx_valid) |
| rx_crc_ok | input | 1 | CRC verdict, sampled on the last byte |
| cfg_ctrl_mac | input | 48 | MAC control multicast address |
| cfg_station_mac | input | 48 | Station's own address |
| cfg_type | input | 16 | Expected type value |
| cfg_rx_pause_en | input | 1 | Enables the reaction to received pause frames |
| pause_seen | output | 1 | One-cycle pulse for each accepted pause frame |
| pause_is_xoff | output | 1 | 1 = last accepted frame was XOFF, 0 = XON |
| pause_hold | output | 1 | High while the transmit side must hold off |

## Verification
The assertions check on every cycle the relations that can be seen at the ports. A pulse only follows a last byte with a good CRC, and never follows one while receive pause is disabled. `pause_hold` can only rise on a pulse. An XOFF pulse always comes with hold high, and an XON pulse always comes with hold low. Only the directed scenarios can show the field positions and which addresses, types and opcodes are rejected. They also cover the short-frame cut-off, the exact N*64-cycle hold length, and a reload that shortens a pause already running.

// File: rtl/pause_rx_pkg.sv
// Shared constants for the pause frame receive detector.
package pause_rx_pkg;
    // Position of fields inside the frame, counted from byte 0 of the destination address.
    localparam int DA_LAST_IDX   = 5;
    localparam int TYPE_HI_IDX   = 12;
    localparam int TYPE_LO_IDX   = 13;
    localparam int OP_HI_IDX     = 14;
    localparam int OP_LO_IDX     = 15;
    localparam int TIME_HI_IDX   = 16;
    localparam int TIME_LO_IDX   = 17;
    // Only accepted control opcode.
    localparam logic [15:0] PAUSE_OPCODE = 16'h0001;
    // Number of addresses compared against the destination field.
    localparam int NUM_DA_REFS   = 2;
endpackage

// File: rtl/pause_rx_parser.sv
// Field parser: tracks the byte index of the current frame and accumulates
// the destination, type and opcode matches, and captures the pause time.
// Assumes rx_sof and rx_eof are only meaningful when rx_valid is high, and
// that a frame always starts with rx_sof. frame_ok is combinational and is
// high on the final byte of a frame that passes every check.
module pause_rx_parser
    import pause_rx_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_eof,
    input  logic        rx_crc_ok,
    input  logic [47:0] cfg_ctrl_mac,
    input  logic [47:0] cfg_station_mac,
    input  logic [15:0] cfg_type,
    output logic        frame_ok,
    output logic [15:0] frame_time
);
    localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

    logic [IDX_W-1:0]       idx_q;
    logic [IDX_W-1:0]       cur_idx;
    logic [NUM_DA_REFS-1:0] da_q, da_n;
    logic                   type_q, type_n;
    logic                   op_q, op_n;
    logic [15:0]            time_q, time_n;
    logic [47:0]            da_ref [NUM_DA_REFS];

    assign da_ref[0] = cfg_ctrl_mac;
    assign da_ref[1] = cfg_station_mac;

    // Compare one received byte with byte position i of a 48-bit address.
    function automatic logic addr_byte_eq(input logic [47:0] addr,
                                          input logic [IDX_W-1:0] i,
                                          input logic [7:0] b);
        logic eq;
        eq = 1'b1;
        for (int k = 0; k <= DA_LAST_IDX; k++) begin
            if (i == IDX_W'(k)) eq = (addr[8*(DA_LAST_IDX-k) +: 8] == b);
        end
        return eq;
    endfunction

    // Index of the byte now on the bus; a start marker restarts at zero.
    always_comb cur_idx = rx_sof ? '0 : idx_q;

    // One running destination match per reference address.
    genvar g;
    generate
        for (g = 0; g < NUM_DA_REFS; g++) begin : g_da
            always_comb begin
                da_n[g] = (rx_sof | da_q[g]);
                if (cur_idx <= IDX_W'(DA_LAST_IDX))
                    da_n[g] = da_n[g] & addr_byte_eq(da_ref[g], cur_idx, rx_data);
            end
        end
    endgenerate

    // Running type, opcode and pause time values including the current byte.
    always_comb begin
        type_n = rx_sof | type_q;
        op_n   = rx_sof | op_q;
        time_n = rx_sof ? 16'h0 : time_q;
        case (cur_idx)
            IDX_W'(TYPE_HI_IDX): type_n = type_n & (rx_data == cfg_type[15:8]);
            IDX_W'(TYPE_LO_IDX): type_n = type_n & (rx_data == cfg_type[7:0]);
            IDX_W'(OP_HI_IDX):   op_n   = op_n & (rx_data == PAUSE_OPCODE[15:8]);
            IDX_W'(OP_LO_IDX):   op_n   = op_n & (rx_data == PAUSE_OPCODE[7:0]);
            IDX_W'(TIME_HI_IDX): time_n = {rx_data, time_n[7:0]};
            IDX_W'(TIME_LO_IDX): time_n = {time_n[15:8], rx_data};
            default: ;
        endcase
    end

    // Verdict on the closing byte: all fields seen, all checks passed, CRC good.
    always_comb begin
        frame_ok   = rx_valid & rx_eof & rx_crc_ok
                   & (cur_idx >= IDX_W'(TIME_LO_IDX))
                   & (|da_n) & type_n & op_n;
        frame_time = time_n;
    end

    // Advance the byte index and store the running matches on each valid byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            da_q   <= '0;
            type_q <= 1'b0;
            op_q   <= 1'b0;
            time_q <= 16'h0;
        end else if (rx_valid) begin
            idx_q  <= (cur_idx == IDX_MAX) ? cur_idx : cur_idx + 1'b1;
            da_q   <= da_n;
            type_q <= type_n;
            op_q   <= op_n;
            time_q <= time_n;
        end
    end
endmodule

// File: rtl/pause_slot_timer.sv
// Pause countdown in slot units. A prescaler divides the byte clock by
// SLOT_BYTES. load sets a new count and restarts the prescaler; clear ends
// the pause. hold is high while the count is non-zero.
// Assumes load and clear are never high together.
module pause_slot_timer #(
    parameter int SLOT_BYTES = 64,
    parameter int CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             clear,
    output logic             hold
);
    localparam int PRE_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [PRE_W-1:0] pre_q;

    // Reload, cancel, or step the slot prescaler and count down on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
            pre_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
            pre_q <= '0;
        end else if (cnt_q != '0) begin
            if (pre_q == PRE_LAST) begin
                pre_q <= '0;
                cnt_q <= cnt_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    // Transmit hold-off while slots remain.
    always_comb hold = (cnt_q != '0);
endmodule

// File: rtl/pause_rx_detect.sv
// Top of the pause frame receive detector. Combines the field parser with
// the slot countdown, applies the receive-pause enable and registers the
// detection pulse and XON/XOFF class.
module pause_rx_detect #(
    parameter int SLOT_BYTES = 64,
    parameter int IDX_W      = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_eof,
    input  logic        rx_crc_ok,
    input  logic [47:0] cfg_ctrl_mac,
    input  logic [47:0] cfg_station_mac,
    input  logic [15:0] cfg_type,
    input  logic        cfg_rx_pause_en,
    output logic        pause_seen,
    output logic        pause_is_xoff,
    output logic        pause_hold
);
    logic        frame_ok;
    logic [15:0] frame_time;
    logic        accept;
    logic        time_nz;

    pause_rx_parser #(.IDX_W(IDX_W)) u_parser (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_sof          (rx_sof),
        .rx_valid        (rx_valid),
        .rx_data         (rx_data),
        .rx_eof          (rx_eof),
        .rx_crc_ok       (rx_crc_ok),
        .cfg_ctrl_mac    (cfg_ctrl_mac),
        .cfg_station_mac (cfg_station_mac),
        .cfg_type        (cfg_type),
        .frame_ok        (frame_ok),
        .frame_time      (frame_time)
    );

    // Gate the verdict with the receive-side enable.
    always_comb begin
        accept  = frame_ok & cfg_rx_pause_en;
        time_nz = (frame_time != 16'h0);
    end

    pause_slot_timer #(.SLOT_BYTES(SLOT_BYTES), .CNT_W(16)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept & time_nz),
        .load_val (frame_time),
        .clear    (accept & ~time_nz),
        .hold     (pause_hold)
    );

    // Register the detection pulse and keep the class of the last accepted frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_seen    <= 1'b0;
            pause_is_xoff <= 1'b0;
        end else begin
            pause_seen <= accept;
            if (accept) pause_is_xoff <= time_nz;
        end
    end
endmodule

// File: rtl/pause_rx_detect_chk.sv
// Port-level checker for pause_rx_detect, attached with bind.
module pause_rx_detect_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_sof,
    input logic        rx_valid,
    input logic [7:0]  rx_data,
    input logic        rx_eof,
    input logic        rx_crc_ok,
    input logic [47:0] cfg_ctrl_mac,
    input logic [47:0] cfg_station_mac,
    input logic [15:0] cfg_type,
    input logic        cfg_rx_pause_en,
    input logic        pause_seen,
    input logic        pause_is_xoff,
    input logic        pause_hold
);
    // A pulse only follows a closing byte that carried a good CRC.
    assert_seen_after_good_eof_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |-> $past(rx_valid && rx_eof && rx_crc_ok));

    // No pulse while the receive-side reaction was disabled.
    assert_disabled_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |-> $past(cfg_rx_pause_en));

    // Hold only starts on an accepted XOFF.
    assert_hold_rises_on_xoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_hold) |-> (pause_seen && pause_is_xoff));

    // An XOFF pulse always comes with an active hold.
    assert_xoff_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_seen && pause_is_xoff) |-> pause_hold);

    // An XON pulse always ends the hold in the same cycle.
    assert_xon_cancels_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_seen && !pause_is_xoff) |-> !pause_hold);

    // The pulse is a single cycle wide.
    assert_pulse_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pause_seen |=> !pause_seen);
endmodule

bind pause_rx_detect pause_rx_detect_chk u_chk (.*);

// File: tb/sim_pause_rx_detect.sv
module sim_pause_rx_detect;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT = 64;
    localparam logic [47:0] CTRL_MAC = 48'h0180C2000001;
    localparam logic [47:0] STA_MAC  = 48'h02AABBCCDDEE;
    localparam logic [15:0] TYPE_V   = 16'h8808;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_sof = 1'b0, rx_valid = 1'b0, rx_eof = 1'b0, rx_crc_ok = 1'b0;
    logic [7:0]  rx_data = 8'h0;
    logic        cfg_rx_pause_en = 1'b1;
    logic        pause_seen, pause_is_xoff, pause_hold;

    int checks = 0;
    int errors = 0;
    logic got_seen, got_xoff, got_hold;

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_rx_detect u0 (
        .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_eof(rx_eof), .rx_crc_ok(rx_crc_ok),
        .cfg_ctrl_mac(CTRL_MAC), .cfg_station_mac(STA_MAC), .cfg_type(TYPE_V),
        .cfg_rx_pause_en(cfg_rx_pause_en), .pause_seen(pause_seen),
        .pause_is_xoff(pause_is_xoff), .pause_hold(pause_hold)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int i, input logic [47:0] da,
                                         input logic [15:0] ty, input logic [15:0] op,
                                         input logic [15:0] tm);
        if (i < 6)   return da[8*(5-i) +: 8];
        if (i < 12)  return 8'hA0 + 8'(i);
        case (i)
            12: return ty[15:8];
            13: return ty[7:0];
            14: return op[15:8];
            15: return op[7:0];
            16: return tm[15:8];
            17: return tm[7:0];
            default: return 8'h00;
        endcase
    endfunction

    // Send one frame; on return it is the negedge after the closing byte's edge.
    task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op,
                        input logic [15:0] tm, input int len, input bit crc);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid  = 1'b1;
            rx_sof    = (i == 0);
            rx_eof    = (i == len-1);
            rx_crc_ok = crc && (i == len-1);
            rx_data   = fbyte(i, da, ty, op, tm);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0; rx_data = 8'h0;
        got_seen = pause_seen; got_xoff = pause_is_xoff; got_hold = pause_hold;
    endtask

    // Count negedges with hold high, starting at the current one.
    task automatic hold_len(output int n);
        n = 0;
        while (pause_hold && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R11 seen", int'(pause_seen), 0);
        chk("R11 xoff", int'(pause_is_xoff), 0);
        chk("R11 hold", int'(pause_hold), 0);
    endtask

    task automatic t_xoff_ctrl;
        int n;
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd2, 60, 1'b1);
        chk("R1 ctrl address accepted", int'(got_seen), 1);
        chk("R5 xoff class", int'(got_xoff), 1);
        @(negedge clk);
        chk("R4 pulse one cycle", int'(pause_seen), 0);
        n = 1;
        while (pause_hold && n < 100000) begin n++; @(negedge clk); end
        chk("R6 hold length 2 slots", n, 2*SLOT);
    endtask

    task automatic t_station;
        int n;
        send(STA_MAC, TYPE_V, 16'h0001, 16'd1, 64, 1'b1);
        chk("R1 station address accepted", int'(got_seen), 1);
        hold_len(n);
        chk("R6 hold length 1 slot", n, SLOT);
    endtask

    task automatic t_rejects;
        send(48'h0180C2000002, TYPE_V, 16'h0001, 16'd5, 60, 1'b1);
        chk("R1 other address rejected", int'(got_seen), 0);
        send(CTRL_MAC, 16'h8809, 16'h0001, 16'd5, 60, 1'b1);
        chk("R2 wrong type rejected", int'(got_seen), 0);
        send(CTRL_MAC, TYPE_V, 16'h0101, 16'd5, 60, 1'b1);
        chk("R3 wrong opcode rejected", int'(got_seen), 0);
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd5, 60, 1'b0);
        chk("R4 bad crc rejected", int'(got_seen), 0);
        chk("R4 bad crc no hold", int'(got_hold), 0);
    endtask

    task automatic t_short;
        int n;
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd1, 17, 1'b1);
        chk("R10 17-byte frame rejected", int'(got_seen), 0);
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd1, 18, 1'b1);
        chk("R10 18-byte frame accepted", int'(got_seen), 1);
        hold_len(n);
        chk("R6 hold after 18-byte frame", n, SLOT);
    endtask

    task automatic t_xon;
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd10, 60, 1'b1);
        chk("R6 hold active", int'(got_hold), 1);
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd0, 60, 1'b1);
        chk("R7 xon seen", int'(got_seen), 1);
        chk("R5 xon class", int'(got_xoff), 0);
        chk("R7 xon clears hold", int'(got_hold), 0);
    endtask

    task automatic t_reload;
        int n;
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd3, 60, 1'b1);
        repeat (20) @(negedge clk);
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd1, 60, 1'b1);
        chk("R8 reload seen", int'(got_seen), 1);
        hold_len(n);
        chk("R8 reload replaces remaining time", n, SLOT);
    endtask

    task automatic t_disabled;
        cfg_rx_pause_en = 1'b0;
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd4, 60, 1'b1);
        chk("R9 disabled xoff no pulse", int'(got_seen), 0);
        chk("R9 disabled xoff no hold", int'(got_hold), 0);
        cfg_rx_pause_en = 1'b1;
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd4, 60, 1'b1);
        cfg_rx_pause_en = 1'b0;
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd0, 60, 1'b1);
        chk("R9 disabled xon no pulse", int'(got_seen), 0);
        chk("R9 disabled xon keeps hold", int'(got_hold), 1);
        chk("R9 class unchanged", int'(got_xoff), 1);
        cfg_rx_pause_en = 1'b1;
        send(CTRL_MAC, TYPE_V, 16'h0001, 16'd0, 60, 1'b1);
        chk("R7 re-enabled xon clears", int'(got_hold), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_xoff_ctrl();
        t_station();
        t_rejects();
        t_short();
        t_xon();
        t_reload();
        t_disabled();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule